// File: doc/BRIEF.md
# Two-Channel Sequential Break Trigger

This block turns the per-cycle hit pulses of two break-condition channels, A and B, into a single-cycle user-break request. The hits come from address and data comparators outside the block. Each channel sees one hit line per bus, and a per-channel select picks which bus line counts as that channel's hit. A mode bit chooses between two ways of working. In independent mode, either channel raises the request. In sequential mode, a hit on A arms the block, and only a strictly later hit on B raises the request.

Each channel has a sticky flag that records its hits. Software can clear a flag but cannot set it. An optional execution count gates channel B: each B hit counts the register down while it is above 1, and the B hit that finds the count at 1 (or 0) completes the B condition. Disarming a pending A hit needs two things: the mode bit must be returned to independent mode, and the channel A flag must be cleared.

Top module: `seq_break_trigger`

## Requirements
- R1: Each channel's hit is `x_match[sel]`, where `sel` is that channel's registered bus select (index 0 is the L bus, index 1 is the I bus). Hit lines of unselected buses are ignored.
- R2: In independent mode (`cfg_seq`=0), a hit on A, or a completed B condition, drives `break_req` high in the next cycle. The same event sets that channel's flag.
- R3: In sequential mode (`cfg_seq`=1), `break_req` rises one cycle after a completed B condition only when the block was already armed by an earlier A hit. A B condition with the block unarmed gives no request.
- R4: In sequential mode, A and B hitting in the same cycle while unarmed gives no request, and the block becomes armed.
- R5: `break_req` lasts one cycle per triggering event. A sequential break clears the armed state in the same edge, and an A hit in that same cycle does not re-arm.
- R6: The armed state is cleared, apart from firing, only when the registered mode is independent and flag A is 0 at the same time. Either of these alone leaves the block armed.
- R7: The flags are set only by hardware. A `flag_wr` with a 0 in bit 0 (A) or bit 1 (B) clears that flag, and a 1 leaves it unchanged. A hardware set in the same cycle wins over a clear.
- R8: With `cfg_cnt_en`=1, each B hit decrements `cnt_value` while it is above 1. The B condition completes only on a hit that finds `cnt_value` at 1 or below. With `cfg_cnt_en`=0, every B hit completes it. A `cnt_wr` loads `cnt_wdata` and takes priority over the decrement.
- R9: After reset, `break_req`, both flags and `seq_armed` are 0, `cnt_value` is 1, and all mode bits and selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_match | input | NUM_BUS | Channel A comparator hits, one per bus |
| b_match | input | NUM_BUS | Channel B comparator hits, one per bus |
| cfg_we | input | 1 | Loads the mode and select fields below |
| cfg_seq | input | 1 | 1 = sequential mode |
| cfg_cnt_en | input | 1 | 1 = execution count gates channel B |
| cfg_a_sel | input | SEL_W | Channel A bus select |
| cfg_b_sel | input | SEL_W | Channel B bus select |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Bit 0 = A, bit 1 = B; 0 clears, 1 keeps |
| cnt_wr | input | 1 | Count register load strobe |
| cnt_wdata | input | CNT_W | Count load value |
| break_req | output | 1 | Break request pulse |
| flag_a | output | 1 | Channel A sticky flag |
| flag_b | output | 1 | Channel B sticky flag |
| seq_armed | output | 1 | Sequential armed state |
| cnt_value | output | CNT_W | Execution count register |

## Verification
The assertions check on every cycle that an unarmed block in sequential mode never requests a break, that a sequential break leaves the block disarmed, and that the armed state survives while either disarm condition is missing. They also check that a flag neither drops without a clearing write nor rises without a hit, and that each counted B hit lowers the count by exactly one. Only the bench scenarios can show that the right bus line is chosen, and how a simultaneous A and B hit plays out over the following cycles. The two disarm orderings and the count reaching 1 and then firing are also shown only by the scenarios, each checked against the behavioural model.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
   typedef struct packed {
      logic seq;
      logic cnt_en;
   } sbt_mode_t;
   localparam int unsigned SBT_NUM_CH = 2;
endpackage

// File: rtl/sbt_chan_sel.sv
module sbt_chan_sel #(
   parameter int unsigned NUM_BUS = 2,
   parameter int unsigned SEL_W   = 1
) (
   input  logic [NUM_BUS-1:0] match,
   input  logic [SEL_W-1:0]   sel,
   output logic               hit
);
   generate
      if (NUM_BUS == 2) begin : g_two
         assign hit = sel[0] ? match[1] : match[0];
      end else begin : g_many
         always_comb begin
            hit = 1'b0;
            for (int i = 0; i < NUM_BUS; i++) begin
               if (int'(sel) == i) hit = match[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sbt_exec_count.sv
module sbt_exec_count #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             hit,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic at_last;
   assign at_last = (cnt <= ONE);
   assign done    = hit & (~en | at_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= ONE;
      end else if (wr) begin
         cnt <= wdata;
      end else if (en && hit && !at_last) begin
         cnt <= cnt - ONE;
      end
   end
endmodule

// File: rtl/sbt_seq_core.sv
module sbt_seq_core (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       seq,
   input  logic       hit_a,
   input  logic       b_done,
   input  logic       flag_wr,
   input  logic [1:0] flag_wdata,
   output logic       break_req,
   output logic       flag_a,
   output logic       flag_b,
   output logic       armed
);
   logic fire, armed_d, brk_d, fa_d, fb_d;

   assign fire = seq & armed & b_done;

   always_comb begin
      armed_d = armed;
      if (fire)                armed_d = 1'b0;
      else if (seq && hit_a)   armed_d = 1'b1;
      else if (!seq && !flag_a) armed_d = 1'b0;

      brk_d = seq ? fire : (hit_a | b_done);

      fa_d = flag_a;
      if (hit_a)                         fa_d = 1'b1;
      else if (flag_wr && !flag_wdata[0]) fa_d = 1'b0;

      fb_d = flag_b;
      if (b_done)                        fb_d = 1'b1;
      else if (flag_wr && !flag_wdata[1]) fb_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         break_req <= 1'b0;
         flag_a    <= 1'b0;
         flag_b    <= 1'b0;
      end else begin
         armed     <= armed_d;
         break_req <= brk_d;
         flag_a    <= fa_d;
         flag_b    <= fb_d;
      end
   end
endmodule

// File: rtl/seq_break_trigger.sv
module seq_break_trigger #(
   parameter int unsigned NUM_BUS = 2,
   parameter int unsigned CNT_W   = 12,
   localparam int unsigned SEL_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_BUS-1:0] a_match,
   input  logic [NUM_BUS-1:0] b_match,
   input  logic               cfg_we,
   input  logic               cfg_seq,
   input  logic               cfg_cnt_en,
   input  logic [SEL_W-1:0]   cfg_a_sel,
   input  logic [SEL_W-1:0]   cfg_b_sel,
   input  logic               flag_wr,
   input  logic [1:0]         flag_wdata,
   input  logic               cnt_wr,
   input  logic [CNT_W-1:0]   cnt_wdata,
   output logic               break_req,
   output logic               flag_a,
   output logic               flag_b,
   output logic               seq_armed,
   output logic [CNT_W-1:0]   cnt_value
);
   import sbt_pkg::*;

   generate
      if (NUM_BUS < 2) begin : g_bad_bus
         initial $error("seq_break_trigger: NUM_BUS must be at least 2");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         initial $error("seq_break_trigger: CNT_W must be at least 2");
      end
   endgenerate

   sbt_mode_t        mode_q;
   logic [SEL_W-1:0] sel_q [SBT_NUM_CH];
   logic             seq_q, cnt_en_q;
   logic             hit_a, hit_b, b_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         sel_q[0] <= '0;
         sel_q[1] <= '0;
      end else if (cfg_we) begin
         mode_q.seq    <= cfg_seq;
         mode_q.cnt_en <= cfg_cnt_en;
         sel_q[0]      <= cfg_a_sel;
         sel_q[1]      <= cfg_b_sel;
      end
   end

   assign seq_q    = mode_q.seq;
   assign cnt_en_q = mode_q.cnt_en;

   sbt_chan_sel #(.NUM_BUS(NUM_BUS), .SEL_W(SEL_W)) u_sel_a (
      .match(a_match), .sel(sel_q[0]), .hit(hit_a)
   );
   sbt_chan_sel #(.NUM_BUS(NUM_BUS), .SEL_W(SEL_W)) u_sel_b (
      .match(b_match), .sel(sel_q[1]), .hit(hit_b)
   );

   sbt_exec_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(cnt_en_q), .hit(hit_b),
      .wr(cnt_wr), .wdata(cnt_wdata), .cnt(cnt_value), .done(b_done)
   );

   sbt_seq_core u_core (
      .clk(clk), .rst_n(rst_n), .seq(seq_q), .hit_a(hit_a), .b_done(b_done),
      .flag_wr(flag_wr), .flag_wdata(flag_wdata), .break_req(break_req),
      .flag_a(flag_a), .flag_b(flag_b), .armed(seq_armed)
   );
endmodule

// File: rtl/sbt_chk.sv
module sbt_chk #(
   parameter int unsigned CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             seq_q,
   input logic             cnt_en_q,
   input logic             hit_a,
   input logic             hit_b,
   input logic             b_done,
   input logic             flag_wr,
   input logic [1:0]       flag_wdata,
   input logic             cnt_wr,
   input logic             break_req,
   input logic             flag_a,
   input logic             flag_b,
   input logic             seq_armed,
   input logic [CNT_W-1:0] cnt_value
);
   // R3
   unarmed_no_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_q && !seq_armed) |=> !break_req);

   // R4
   simul_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_q && !seq_armed && hit_a && hit_b) |=> (seq_armed && !break_req));

   // R5
   fire_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (break_req && $past(seq_q)) |-> !seq_armed);

   // R6
   armed_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_armed && (seq_q || flag_a) && !(seq_q && b_done)) |=> seq_armed);

   // R7
   flag_a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_a && !(flag_wr && !flag_wdata[0])) |=> flag_a);

   // R7
   flag_b_no_self_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_b && !b_done) |=> !flag_b);

   // R8
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en_q && hit_b && (cnt_value > CNT_W'(1)) && !cnt_wr)
      |=> (cnt_value == $past(cnt_value) - CNT_W'(1)));
endmodule

bind seq_break_trigger sbt_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_seq_break_trigger.sv
module tb_seq_break_trigger;
   localparam int CW = 12;

   logic clk = 0, rst_n = 0;
   logic [1:0] a_match = 0, b_match = 0;
   logic cfg_we = 0, cfg_seq = 0, cfg_cnt_en = 0;
   logic [0:0] cfg_a_sel = 0, cfg_b_sel = 0;
   logic flag_wr = 0;
   logic [1:0] flag_wdata = 0;
   logic cnt_wr = 0;
   logic [CW-1:0] cnt_wdata = 0;
   logic break_req, flag_a, flag_b, seq_armed;
   logic [CW-1:0] cnt_value;

   int n_chk = 0, n_fail = 0;

   // behavioural reference state
   int m_seq = 0, m_cen = 0, m_sa = 0, m_sb = 0, m_cnt = 1;
   int m_arm = 0, m_fa = 0, m_fb = 0, m_brk = 0;

   seq_break_trigger #(.NUM_BUS(2), .CNT_W(CW)) dut (.*);

   always #5 clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_seq = 0; m_cen = 0; m_sa = 0; m_sb = 0; m_cnt = 1;
         m_arm = 0; m_fa = 0; m_fb = 0; m_brk = 0;
      end else begin
         int ha, hb, bd, fire, n_arm, n_fa, n_fb, n_cnt;
         ha = int'(a_match[m_sa]);
         hb = int'(b_match[m_sb]);
         bd = (hb != 0) && (m_cen == 0 || m_cnt <= 1);
         fire = (m_seq != 0) && (m_arm != 0) && (bd != 0);
         n_arm = m_arm;
         if (fire != 0) n_arm = 0;
         else if (m_seq != 0 && ha != 0) n_arm = 1;
         else if (m_seq == 0 && m_fa == 0) n_arm = 0;
         n_fa = (ha != 0) ? 1 : (flag_wr && !flag_wdata[0]) ? 0 : m_fa;
         n_fb = (bd != 0) ? 1 : (flag_wr && !flag_wdata[1]) ? 0 : m_fb;
         n_cnt = m_cnt;
         if (cnt_wr) n_cnt = int'(cnt_wdata);
         else if (m_cen != 0 && hb != 0 && m_cnt > 1) n_cnt = m_cnt - 1;
         m_brk = (m_seq != 0) ? fire : ((ha != 0 || bd != 0) ? 1 : 0);
         m_arm = n_arm; m_fa = n_fa; m_fb = n_fb; m_cnt = n_cnt;
         if (cfg_we) begin
            m_seq = int'(cfg_seq); m_cen = int'(cfg_cnt_en);
            m_sa = int'(cfg_a_sel); m_sb = int'(cfg_b_sel);
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      chk("model break_req", int'(break_req), m_brk);
      chk("model flag_a", int'(flag_a), m_fa);
      chk("model flag_b", int'(flag_b), m_fb);
      chk("model seq_armed", int'(seq_armed), m_arm);
      chk("model cnt_value", int'(cnt_value), m_cnt);
   endtask

   task automatic set_mode(logic s, logic c, logic sa, logic sb);
      cfg_seq = s; cfg_cnt_en = c; cfg_a_sel = sa; cfg_b_sel = sb; cfg_we = 1;
      cyc();
      cfg_we = 0;
   endtask

   task automatic hit(logic [1:0] av, logic [1:0] bv);
      a_match = av; b_match = bv;
      cyc();
      a_match = 0; b_match = 0;
   endtask

   task automatic fwrite(logic [1:0] d);
      flag_wr = 1; flag_wdata = d;
      cyc();
      flag_wr = 0;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1;
      cyc();
      // R9 reset state
      chk("R9 break_req", int'(break_req), 0);
      chk("R9 flags", int'({flag_a, flag_b}), 0);
      chk("R9 armed", int'(seq_armed), 0);
      chk("R9 count", int'(cnt_value), 1);

      // R2 independent mode, A on L bus
      set_mode(0, 0, 0, 0);
      hit(2'b01, 2'b00);
      chk("R2 A break", int'(break_req), 1);
      chk("R2 A flag", int'(flag_a), 1);
      cyc();
      chk("R5 pulse one cycle", int'(break_req), 0);
      hit(2'b00, 2'b01);
      chk("R2 B break", int'(break_req), 1);
      chk("R2 B flag", int'(flag_b), 1);

      // R7 write 1 keeps, write 0 clears
      fwrite(2'b11);
      chk("R7 write one keeps A", int'(flag_a), 1);
      chk("R7 write one keeps B", int'(flag_b), 1);
      fwrite(2'b00);
      chk("R7 write zero clears", int'({flag_a, flag_b}), 0);
      flag_wr = 1; flag_wdata = 2'b00; a_match = 2'b01;
      cyc();
      flag_wr = 0; a_match = 0;
      chk("R7 hardware set wins", int'(flag_a), 1);
      fwrite(2'b00);

      // R1 bus select
      hit(2'b10, 2'b10);
      chk("R1 unselected bus ignored", int'(break_req), 0);
      set_mode(0, 0, 1, 1);
      hit(2'b10, 2'b00);
      chk("R1 I bus selected", int'(break_req), 1);
      hit(2'b01, 2'b00);
      chk("R1 L bus now ignored", int'(break_req), 0);
      fwrite(2'b00);

      // R3 sequential ordering
      set_mode(1, 0, 0, 0);
      hit(2'b00, 2'b01);
      chk("R3 B before A no break", int'(break_req), 0);
      hit(2'b01, 2'b00);
      chk("R3 A arms", int'(seq_armed), 1);
      chk("R3 A alone no break", int'(break_req), 0);
      hit(2'b00, 2'b01);
      chk("R3 B after A breaks", int'(break_req), 1);
      chk("R5 fire disarms", int'(seq_armed), 0);
      fwrite(2'b00);

      // R4 simultaneous
      hit(2'b01, 2'b01);
      chk("R4 simultaneous no break", int'(break_req), 0);
      chk("R4 simultaneous arms", int'(seq_armed), 1);
      hit(2'b00, 2'b01);
      chk("R4 later B breaks", int'(break_req), 1);

      // R6 disarm: flag clear alone, then mode clear
      hit(2'b01, 2'b00);
      fwrite(2'b00);
      cyc();
      chk("R6 flag clear alone keeps armed", int'(seq_armed), 1);
      set_mode(0, 0, 0, 0);
      cyc();
      chk("R6 both cleared disarms", int'(seq_armed), 0);
      // R6 other order
      set_mode(1, 0, 0, 0);
      hit(2'b01, 2'b00);
      set_mode(0, 0, 0, 0);
      cyc();
      chk("R6 mode clear alone keeps armed", int'(seq_armed), 1);
      fwrite(2'b00);
      cyc();
      chk("R6 mode then flag disarms", int'(seq_armed), 0);

      // R8 execution count in sequential mode
      set_mode(1, 1, 0, 0);
      cnt_wr = 1; cnt_wdata = CW'(3);
      cyc();
      cnt_wr = 0;
      chk("R8 count load", int'(cnt_value), 3);
      hit(2'b01, 2'b00);
      hit(2'b00, 2'b01);
      chk("R8 count 3 to 2", int'(cnt_value), 2);
      chk("R8 no break above one", int'(break_req), 0);
      hit(2'b00, 2'b01);
      chk("R8 count 2 to 1", int'(cnt_value), 1);
      chk("R8 still no break", int'(break_req), 0);
      hit(2'b00, 2'b01);
      chk("R8 break at one", int'(break_req), 1);
      chk("R8 count stays one", int'(cnt_value), 1);

      // random traffic against the model
      for (int i = 0; i < 400; i++) begin
         a_match = 2'($urandom); b_match = 2'($urandom);
         flag_wr = ($urandom % 6) == 0; flag_wdata = 2'($urandom);
         cnt_wr = ($urandom % 15) == 0; cnt_wdata = CW'($urandom % 4);
         cfg_we = ($urandom % 20) == 0;
         cfg_seq = 1'($urandom); cfg_cnt_en = 1'($urandom);
         cfg_a_sel = 1'($urandom); cfg_b_sel = 1'($urandom);
         cyc();
      end
      a_match = 0; b_match = 0; flag_wr = 0; cnt_wr = 0; cfg_we = 0;
      cyc();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule